// File: doc/BRIEF.md
# Serial Audio Output Formatter

This block sits behind a digital audio receiver front end. It takes decoded 32-bit stereo sub-frames from that front end and sends them out as master of a three-wire serial audio link: a frame clock that marks left and right, a bit clock that it generates at 64 times the frame rate, and one data line. A 3-bit format code picks the alignment of the word inside its 32-slot half-frame (right-justified, left-justified or I2S) and the word length (16, 18, 20 or 24 bits). Audio leaves MSB-first in two's complement.

The block also conceals bad input. Each sub-frame arrives with three error flags: parity, biphase and frame length. When any of them is set, the block keeps the last good sample of that channel and sends it again. While the receiver reports loss of lock, the data line stays at zero. Sub-frames enter through a valid/ready stream. Each channel has a one-entry slot, so a new sub-frame for a channel is accepted only when that channel's slot is free. A sub-frame is held until that channel's next half-frame begins. When no new sub-frame has arrived by then, the channel sends its last good sample again.

Top module: `sao_formatter`

## Requirements
- R1: During reset, bick is 1, lrck is 0, sdata is 0 and in_ready is 1. Both stored samples are cleared to zero, so frames sent before any sub-frame is accepted carry only zero bits.
- R2: sdata and lrck change only on a falling edge of bick. One bick period lasts 2*HALF_DIV clk cycles, and a frame lasts 64 bick periods, with the left half (slots 0 to 31) first.
- R3: The fmt_sel code sets the framing. Codes 0, 1, 2 and 3 are right-justified with 16, 18, 20 and 24 bits, and the LSB sits in slot 31 of the half. Code 4 is left-justified 24-bit, with the MSB in slot 0. Code 5 is I2S 24-bit, with the MSB in slot 1. Codes 6 and 7 act as 4 and 5. Bits go out MSB first, and every slot outside the word carries 0.
- R4: For codes 0 to 4 and 6, lrck is 1 during the left half. For codes 5 and 7, lrck is 0 during the left half.
- R5: The 24-bit sample is sub-frame bits 27:8 (audio, with the MSB at bit 27) placed above bits 7:4 (auxiliary nibble). A word length of L bits sends only the top L bits of this sample, so the shorter formats drop the auxiliary nibble and the lowest audio bits.
- R6: A sub-frame is accepted on a clk edge where in_valid and in_ready are both 1. in_chan selects the channel (0 is left, 1 is right). in_ready is 1 exactly when that channel's slot is empty. A full slot holds off further sub-frames for that channel until the slot is used at the start of that channel's next half-frame. The error flags are sampled together with the word.
- R7: A sub-frame accepted with in_parity_err, in_biphase_err or in_len_err set does not replace the stored sample. That channel sends its previous good sample again. Left and right keep separate stored samples.
- R8: A channel whose half-frame starts with its slot empty sends its stored sample again.
- R9: While unlock is 1, sdata is 0. A sub-frame that is used while unlock is 1 is dropped, and the stored sample is kept for use after lock returns.
- R10: A new fmt_sel value takes effect only at the start of the next left half-frame. A frame already in progress finishes in the format it started with.
- R11: Sub-frame bits 3:0 and 31:28 have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; bick is divided from it |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_sel | input | 3 | Framing and word-length code (R3) |
| unlock | input | 1 | Receiver not locked; forces the data line to zero |
| in_valid | input | 1 | Sub-frame stream valid |
| in_ready | output | 1 | Slot of the channel selected by in_chan is free |
| in_chan | input | 1 | Channel of the offered sub-frame: 0 left, 1 right |
| in_word | input | 32 | Received sub-frame, with the bit layout of R5 |
| in_parity_err | input | 1 | Parity error flag for this sub-frame |
| in_biphase_err | input | 1 | Biphase coding error flag for this sub-frame |
| in_len_err | input | 1 | Frame length error flag for this sub-frame |
| bick | output | 1 | Bit clock, 64 per frame |
| lrck | output | 1 | Frame clock selecting left or right |
| sdata | output | 1 | Serial audio data, updated on falling bick |

## Verification
A wrong stored sample can only show as a whole half-frame with wrong bits. A held value that the concealment path failed to protect shows in the very next frame on that channel, within at most 64 bick periods. A format latch that loads at the wrong time shows as the wrong lrck polarity or a shifted word in the frame already in progress, so the bench changes the code partway through a frame. A stuck channel slot shows at once as in_ready staying low, or as a sub-frame that never reaches the line.

// File: rtl/sao_pkg.sv
package sao_pkg;
  localparam int SUB_W     = 32;
  localparam int SAMPLE_W  = 24;
  localparam int HALF_BITS = 32;
  localparam int NCH       = 2;

  typedef enum logic [1:0] {
    ALIGN_RIGHT = 2'd0,
    ALIGN_LEFT  = 2'd1,
    ALIGN_I2S   = 2'd2
  } align_e;

  typedef struct packed {
    align_e     align;
    logic [4:0] wlen;
  } fmt_t;

  function automatic fmt_t decode_fmt(input logic [2:0] code);
    fmt_t f;
    case (code)
      3'd0:       f = '{align: ALIGN_RIGHT, wlen: 5'd16};
      3'd1:       f = '{align: ALIGN_RIGHT, wlen: 5'd18};
      3'd2:       f = '{align: ALIGN_RIGHT, wlen: 5'd20};
      3'd3:       f = '{align: ALIGN_RIGHT, wlen: 5'd24};
      3'd5, 3'd7: f = '{align: ALIGN_I2S,   wlen: 5'd24};
      default:    f = '{align: ALIGN_LEFT,  wlen: 5'd24};
    endcase
    return f;
  endfunction

  // audio above auxiliary nibble; preamble and status bits are discarded
  function automatic logic [SAMPLE_W-1:0] take_sample(input logic [SUB_W-1:0] w);
    return {w[27:8], w[7:4]};
  endfunction
endpackage

// File: rtl/sao_bitclk.sv
module sao_bitclk #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic       bick,
  output logic       tick,
  output logic [5:0] bit_cnt,
  output logic [5:0] bit_nxt
);
  localparam int DIV_N = 2 * HALF_DIV;
  localparam int DIV_W = (DIV_N > 1) ? $clog2(DIV_N) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV_N - 1);
  localparam logic [DIV_W-1:0] MID  = DIV_W'(HALF_DIV - 1);

  logic [DIV_W-1:0] div_cnt;

  assign tick    = (div_cnt == LAST);
  assign bit_nxt = bit_cnt + 6'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt <= LAST;
      bick    <= 1'b1;
      bit_cnt <= 6'd63;
    end else begin
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (tick) begin
        bick    <= 1'b0;
        bit_cnt <= bit_nxt;
      end else if (div_cnt == MID) begin
        bick <= 1'b1;
      end
    end
  end

  p_fall_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !bick);
  p_bick_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && div_cnt != MID) |=> $stable(bick));
endmodule

// File: rtl/sao_chan_buf.sv
module sao_chan_buf
  import sao_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_valid,
  input  logic                             in_chan,
  input  logic [SUB_W-1:0]                 in_word,
  input  logic                             in_err,
  input  logic                             unlock,
  input  logic [NCH-1:0]                   consume,
  output logic                             in_ready,
  output logic [NCH-1:0][SAMPLE_W-1:0]     held_nxt
);
  logic [NCH-1:0]               pend_v;
  logic [NCH-1:0]               pend_err;
  logic [NCH-1:0][SAMPLE_W-1:0] pend_s;
  logic [NCH-1:0][SAMPLE_W-1:0] held;

  assign in_ready = !pend_v[in_chan];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic accept;
    logic take_new;

    assign accept   = in_valid && in_ready && (in_chan == 1'(c));
    assign take_new = consume[c] && pend_v[c] && !pend_err[c] && !unlock;
    assign held_nxt[c] = take_new ? pend_s[c] : held[c];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_v[c]   <= 1'b0;
        pend_err[c] <= 1'b0;
        pend_s[c]   <= '0;
        held[c]     <= '0;
      end else begin
        held[c] <= held_nxt[c];
        if (accept) begin
          pend_v[c]   <= 1'b1;
          pend_err[c] <= in_err;
          pend_s[c]   <= take_sample(in_word);
        end else if (consume[c]) begin
          pend_v[c] <= 1'b0;
        end
      end
    end

    p_err_keeps_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (consume[c] && pend_v[c] && pend_err[c]) |=> $stable(held[c]));
    p_unlock_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (consume[c] && unlock) |=> $stable(held[c]));
    p_slot_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_v[c] && !consume[c]) |=> pend_v[c]);
  end
endmodule

// File: rtl/sao_serializer.sv
module sao_serializer
  import sao_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic [5:0]          bit_nxt,
  input  logic [2:0]          fmt_sel,
  input  logic                unlock,
  input  logic [SAMPLE_W-1:0] load_word,
  output logic                lrck,
  output logic                sdata
);
  fmt_t                fmt_act;
  fmt_t                fmt_eff;
  logic [SAMPLE_W-1:0] cur;
  logic [SAMPLE_W-1:0] word_eff;
  logic [SAMPLE_W-1:0] shifted;
  logic                half_start;
  logic                left_start;
  logic [5:0]          slot;
  logic [5:0]          first;
  logic [5:0]          pos;
  logic                in_win;
  logic                bit_v;
  logic                lrck_v;

  assign half_start = tick && (bit_nxt[4:0] == 5'd0);
  assign left_start = half_start && !bit_nxt[5];

  always_comb begin
    fmt_eff  = left_start ? decode_fmt(fmt_sel) : fmt_act;
    word_eff = half_start ? load_word : cur;
    slot     = {1'b0, bit_nxt[4:0]};
    case (fmt_eff.align)
      ALIGN_RIGHT: first = 6'(HALF_BITS) - {1'b0, fmt_eff.wlen};
      ALIGN_I2S:   first = 6'd1;
      default:     first = 6'd0;
    endcase
    pos     = slot - first;
    in_win  = (slot >= first) && (pos < {1'b0, fmt_eff.wlen});
    shifted = word_eff << pos[4:0];
    bit_v   = in_win && shifted[SAMPLE_W-1];
    lrck_v  = (fmt_eff.align == ALIGN_I2S) ? bit_nxt[5] : !bit_nxt[5];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt_act <= decode_fmt(3'd0);
      cur     <= '0;
      lrck    <= 1'b0;
      sdata   <= 1'b0;
    end else if (tick) begin
      fmt_act <= fmt_eff;
      cur     <= word_eff;
      lrck    <= lrck_v;
      sdata   <= bit_v && !unlock;
    end
  end

  p_fmt_at_left_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !left_start |=> $stable(fmt_act));
endmodule

// File: rtl/sao_formatter.sv
module sao_formatter
  import sao_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  fmt_sel,
  input  logic        unlock,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic        in_chan,
  input  logic [31:0] in_word,
  input  logic        in_parity_err,
  input  logic        in_biphase_err,
  input  logic        in_len_err,
  output logic        bick,
  output logic        lrck,
  output logic        sdata
);
  logic                         tick;
  logic [5:0]                   bit_cnt;
  logic [5:0]                   bit_nxt;
  logic [NCH-1:0]               consume;
  logic [NCH-1:0][SAMPLE_W-1:0] held_nxt;
  logic [SAMPLE_W-1:0]          load_word;

  sao_bitclk #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bick    (bick),
    .tick    (tick),
    .bit_cnt (bit_cnt),
    .bit_nxt (bit_nxt)
  );

  assign consume[0] = tick && (bit_nxt == 6'd0);
  assign consume[1] = tick && (bit_nxt == 6'd32);
  assign load_word  = bit_nxt[5] ? held_nxt[1] : held_nxt[0];

  sao_chan_buf u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_chan  (in_chan),
    .in_word  (in_word),
    .in_err   (in_parity_err || in_biphase_err || in_len_err),
    .unlock   (unlock),
    .consume  (consume),
    .in_ready (in_ready),
    .held_nxt (held_nxt)
  );

  sao_serializer u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .bit_nxt   (bit_nxt),
    .fmt_sel   (fmt_sel),
    .unlock    (unlock),
    .load_word (load_word),
    .lrck      (lrck),
    .sdata     (sdata)
  );

  p_data_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(bick) |-> ($stable(sdata) && $stable(lrck)));
  p_unlock_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bick) && $past(unlock)) |-> !sdata);
endmodule

// File: tb/sao_formatter_bench.sv
module sao_formatter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;

  typedef struct {
    int          fmt;
    logic [23:0] sl;
    logic [23:0] sr;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  fmt_sel;
  logic        unlock;
  logic        in_valid;
  logic        in_ready;
  logic        in_chan;
  logic [31:0] in_word;
  logic        in_parity_err;
  logic        in_biphase_err;
  logic        in_len_err;
  logic        bick;
  logic        lrck;
  logic        sdata;

  int   n_cmp = 0;
  int   n_bad = 0;
  int   r2_bad = 0;
  int   mslot = 63;
  exp_t q[$];
  logic [23:0] m_hl = '0;
  logic [23:0] m_hr = '0;
  event ev_slot;

  always #(CLK_PERIOD/2) clk = ~clk;

  sao_formatter #(.HALF_DIV(HALF)) u_sao_formatter (
    .clk            (clk),
    .rst_n          (rst_n),
    .fmt_sel        (fmt_sel),
    .unlock         (unlock),
    .in_valid       (in_valid),
    .in_ready       (in_ready),
    .in_chan        (in_chan),
    .in_word        (in_word),
    .in_parity_err  (in_parity_err),
    .in_biphase_err (in_biphase_err),
    .in_len_err     (in_len_err),
    .bick           (bick),
    .lrck           (lrck),
    .sdata          (sdata)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [23:0] sample_of(input logic [31:0] w);
    return {w[27:8], w[7:4]};
  endfunction

  function automatic logic [31:0] mkw(input logic [19:0] a, input logic [3:0] x, input logic [7:0] j);
    return {j[7:4], a, x, j[3:0]};
  endfunction

  function automatic logic [31:0] exp_half(input int fmt, input logic [23:0] s);
    int L;
    int st;
    logic [31:0] v;
    v = '0;
    case (fmt)
      0: L = 16;
      1: L = 18;
      2: L = 20;
      default: L = 24;
    endcase
    if (fmt <= 3) st = 32 - L;
    else if (fmt == 5 || fmt == 7) st = 1;
    else st = 0;
    for (int k = 0; k < 32; k++)
      if (k >= st && k < st + L) v[k] = s[23-(k-st)];
    return v;
  endfunction

  function automatic logic [63:0] exp_lrck(input int fmt);
    logic lft;
    lft = (fmt == 5 || fmt == 7) ? 1'b0 : 1'b1;
    return {{32{~lft}}, {32{lft}}};
  endfunction

  // monitor: one entry per bick rising edge, compared once a frame is complete
  initial begin
    int   slot;
    int   per;
    bit   seen;
    bit   act;
    logic pb;
    logic ps;
    exp_t cur;
    logic [63:0] gd;
    logic [63:0] gl;
    slot = 63; per = 0; seen = 0; act = 0; pb = 1'b1; ps = 1'b0; gd = '0; gl = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        pb = bick; ps = sdata; slot = 63;
      end else begin
        per++;
        if (sdata !== ps && !(pb && !bick)) r2_bad++;
        if (bick && !pb) begin
          if (seen && per != 2*HALF) r2_bad++;
          seen = 1; per = 0;
          slot = (slot + 1) % 64;
          mslot = slot;
          if (slot == 0) begin
            act = (q.size() > 0);
            if (act) cur = q.pop_front();
          end
          gd[slot] = sdata;
          gl[slot] = lrck;
          if (slot == 63 && act) begin
            chk($sformatf("%s left", cur.tag), {32'd0, gd[31:0]}, {32'd0, exp_half(cur.fmt, cur.sl)});
            chk($sformatf("%s right", cur.tag), {32'd0, gd[63:32]}, {32'd0, exp_half(cur.fmt, cur.sr)});
            chk($sformatf("R4 lrck polarity fmt %0d", cur.fmt), gl, exp_lrck(cur.fmt));
          end
          -> ev_slot;
        end
        pb = bick; ps = sdata;
      end
    end
  end

  task automatic send_sub(input logic ch, input logic [31:0] w, input int ek);
    in_valid = 1'b1; in_chan = ch; in_word = w;
    in_parity_err = (ek == 1); in_biphase_err = (ek == 2); in_len_err = (ek == 3);
    #1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_parity_err = 1'b0; in_biphase_err = 1'b0; in_len_err = 1'b0;
  endtask

  // drives one frame's sub-frames and pushes what the next frame must carry
  task automatic frame(input int fmt, input logic [31:0] lw, input logic [31:0] rw,
                       input int le, input int re, input bit snd, input bit unl, input string tag);
    exp_t e;
    do @(ev_slot); while (mslot != 40);
    fmt_sel = 3'(fmt);
    if (snd) begin
      send_sub(1'b0, lw, le);
      in_valid = 1'b1; in_chan = 1'b0; in_word = 32'hDEAD_BEEF;
      #1;
      chk("R6 full left slot holds off in_ready", {63'd0, in_ready}, 64'd0);
      @(negedge clk);
      in_valid = 1'b0;
      send_sub(1'b1, rw, re);
    end
    e.fmt = fmt;
    e.tag = tag;
    if (unl) begin
      e.sl = '0; e.sr = '0;
    end else begin
      if (snd && le == 0) m_hl = sample_of(lw);
      if (snd && re == 0) m_hr = sample_of(rw);
      e.sl = m_hl; e.sr = m_hr;
    end
    q.push_back(e);
    do @(ev_slot); while (mslot != 63);
    unlock = unl;
  endtask

  initial begin
    rst_n = 1'b0; fmt_sel = 3'd0; unlock = 1'b0; in_valid = 1'b0; in_chan = 1'b0;
    in_word = '0; in_parity_err = 1'b0; in_biphase_err = 1'b0; in_len_err = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 bick in reset", {63'd0, bick}, 64'd1);
    chk("R1 lrck in reset", {63'd0, lrck}, 64'd0);
    chk("R1 sdata in reset", {63'd0, sdata}, 64'd0);
    chk("R1 in_ready in reset", {63'd0, in_ready}, 64'd1);
    rst_n = 1'b1;

    frame(0, '0, '0, 0, 0, 0, 0, "R1 zero samples after reset");
    frame(0, mkw(20'h93A5C, 4'hB, 8'h5A), mkw(20'h6C5A3, 4'h4, 8'hF3), 0, 0, 1, 0, "R3 R5 R11 rj16");
    frame(1, mkw(20'hB1E27, 4'h7, 8'hC3), mkw(20'h48D1F, 4'hE, 8'h0F), 0, 0, 1, 0, "R3 R5 rj18");
    frame(2, mkw(20'hF00F1, 4'h3, 8'hA0), mkw(20'h0FF0E, 4'hC, 8'h77), 0, 0, 1, 0, "R3 R5 rj20");
    frame(3, mkw(20'h8421F, 4'hD, 8'h19), mkw(20'h7BDE0, 4'h2, 8'hE6), 0, 0, 1, 0, "R3 R5 rj24 aux kept");
    frame(4, mkw(20'hC6B35, 4'h9, 8'h3C), mkw(20'h3949A, 4'h6, 8'hD2), 0, 0, 1, 0, "R3 lj24");
    frame(5, mkw(20'hA55AA, 4'hF, 8'h81), mkw(20'h5AA55, 4'h1, 8'h7E), 0, 0, 1, 0, "R3 i2s24");
    frame(6, mkw(20'h12345, 4'h6, 8'hFF), mkw(20'hEDCBA, 4'h9, 8'h00), 0, 0, 1, 0, "R3 code6 as lj");
    frame(7, mkw(20'h80001, 4'h8, 8'h96), mkw(20'h7FFFE, 4'h7, 8'h69), 0, 0, 1, 0, "R3 code7 as i2s");
    frame(4, mkw(20'hDEAD1, 4'h5, 8'h24), mkw(20'h2BEEF, 4'hA, 8'h42), 1, 0, 1, 0, "R7 parity left held");
    frame(4, mkw(20'h13579, 4'h2, 8'h11), mkw(20'h97531, 4'h4, 8'h22), 0, 2, 1, 0, "R7 biphase right held");
    frame(3, mkw(20'hFFFFF, 4'hF, 8'h33), mkw(20'h00000, 4'h0, 8'h44), 3, 3, 1, 0, "R7 length both held");
    frame(3, '0, '0, 0, 0, 0, 0, "R8 no input repeats");
    frame(4, mkw(20'h55555, 4'h5, 8'h55), mkw(20'hAAAAA, 4'hA, 8'hAA), 0, 0, 1, 1, "R9 unlock zero");
    frame(4, '0, '0, 0, 0, 0, 1, "R9 unlock idle zero");
    frame(4, '0, '0, 0, 0, 0, 0, "R9 held kept after relock");
    frame(4, mkw(20'h3C3C3, 4'hC, 8'h5F), mkw(20'hC3C3C, 4'h3, 8'hF5), 0, 0, 1, 0, "R10 before change");
    frame(4, '0, '0, 0, 0, 0, 0, "R10 frame in progress keeps format");
    do @(ev_slot); while (mslot != 5);
    fmt_sel = 3'd5;
    frame(5, mkw(20'h6E6E6, 4'hB, 8'h0C), mkw(20'h9191F, 4'h4, 8'hC0), 0, 0, 1, 0, "R10 new format next frame");

    do @(ev_slot); while (!(q.size() == 0 && mslot == 63));
    chk("R2 steps only on falling bick, period 2*HALF", 64'(r2_bad), 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog (all R): got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule